// File: doc/BRIEF.md
# Serial Core Status and Interrupt Register Block

This block gathers the status of a serial controller's transfer machinery and decides when software must be interrupted. It has three register groups. The operational group mirrors four live FIFO conditions and latches four transfer events: service requests and done indications in each direction. The core error group latches four FIFO overrun and underrun errors. The clock error group latches two serial clock timing errors. Each latched bit stays set until software writes a 1 to it. Writing back the value just read therefore clears exactly the conditions that were seen.

Each error group has its own enable register. The latched operational events have a mask register. The interrupt output is an active-high level. It is the OR of all enabled error flags and all unmasked operational events, and it stays high until every such bit is cleared. A build-time legacy option removes the mask register and permanently disables the core input-overrun error as an interrupt source.

Register access uses a single-cycle write strobe with an address. Read data is combinational from the address. Word addresses: 0 operational, 1 operational mask, 2 core error flags, 3 core error enable, 4 clock error flags, 5 clock error enable. Other addresses read 0.

Top module: `status_irq_regs`

## Requirements
- R1: After reset all flags are 0, `irq_o` is 0, the mask reads 0, the clock error enable reads 0x3, and the core error enable reads 0x3C (0x38 in the legacy build).
- R2: Operational bits 7, 6, 5 and 4 follow `fifo_live_i[3]`, `[2]`, `[1]` and `[0]` (input-full, output-full, input-not-empty, output-not-empty) on every read. Writes have no effect on them.
- R3: A pulse on `op_event_i[3:0]` sets operational bit 11, 10, 9 or 8 (input-done, output-done, input-service, output-service). The bit stays set until it is cleared.
- R4: A write to address 0 clears each of bits 11..8 where the written data is 1, and leaves the bits where it is 0.
- R5: `core_err_i[3:0]` sets core error flag bits 5, 4, 3, 2 (output-overrun, input-underrun, output-underrun, input-overrun). The flags are sticky and clear by writing 1 to address 2.
- R6: `clk_err_i[1:0]` sets clock error flag bits 1 and 0 (clock-overrun, clock-underrun). The flags are sticky and clear by writing 1 to address 4.
- R7: When an event and a write-1 clear of the same bit land in the same cycle, the bit ends set.
- R8: `irq_o` is high while any enabled error flag or any unmasked operational event is set. It goes low only after all of them are cleared.
- R9: An error flag whose enable bit (addresses 3 and 5, same bit positions as the flags) is 0 is still recorded but does not drive `irq_o`. Enabling it later raises `irq_o`.
- R10: A 1 in mask bits 11..8 (address 1) keeps the matching operational event from driving `irq_o`.
- R11: In the legacy build, address 1 reads 0 and ignores writes, so no event is masked. Core enable bit 2 stays 0 even when written with 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_event_i | input | 4 | Event pulses: input-done, output-done, input-service, output-service |
| fifo_live_i | input | 4 | Live levels: input-full, output-full, input-not-empty, output-not-empty |
| core_err_i | input | 4 | Error pulses: output-overrun, input-underrun, output-underrun, input-overrun |
| clk_err_i | input | 2 | Error pulses: clock-overrun, clock-underrun |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data for `reg_addr` |
| irq_o | output | 1 | Level interrupt, active high |

## Verification
The assertions watch four properties on every cycle. An event pulse is always latched even if a clear arrives with it. Latched operational events and core errors never drop without a write to their own address. The interrupt never rises unless an event, an error pulse or a register write came the cycle before. The bench scenarios cover the rest: the bit positions of each field, selective clearing by the written pattern, the live bits surviving a clear, and the interrupt following enable and mask changes. They also cover the legacy build, where the mask register is missing and the input-overrun enable is dropped.

// File: rtl/status_irq_regs.sv
module status_irq_regs #(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 3,
  parameter bit LEGACY = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op_event_i,
  input  logic [3:0]        fifo_live_i,
  input  logic [3:0]        core_err_i,
  input  logic [1:0]        clk_err_i,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq_o
);

  localparam int EV_LSB   = 8;
  localparam int LIVE_LSB = 4;
  localparam int CE_LSB   = 2;
  localparam int SE_LSB   = 0;

  localparam logic [ADDR_W-1:0] A_OP   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CEF  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CEN  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_SEF  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_SEN  = ADDR_W'(5);

  localparam logic [3:0] CE_KEEP = LEGACY ? 4'b1110 : 4'b1111;

  logic [3:0] op_ev, op_mask, ce_flag, ce_en;
  logic [1:0] se_flag, se_en;

  wire wr_op  = reg_wr && (reg_addr == A_OP);
  wire wr_cef = reg_wr && (reg_addr == A_CEF);
  wire wr_cen = reg_wr && (reg_addr == A_CEN);
  wire wr_sef = reg_wr && (reg_addr == A_SEF);
  wire wr_sen = reg_wr && (reg_addr == A_SEN);

  wire [3:0] op_clr = wr_op  ? reg_wdata[EV_LSB +: 4] : 4'b0;
  wire [3:0] ce_clr = wr_cef ? reg_wdata[CE_LSB +: 4] : 4'b0;
  wire [1:0] se_clr = wr_sef ? reg_wdata[SE_LSB +: 2] : 2'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_ev   <= '0;
      ce_flag <= '0;
      se_flag <= '0;
      ce_en   <= CE_KEEP;
      se_en   <= 2'b11;
    end else begin
      op_ev   <= (op_ev & ~op_clr) | op_event_i;
      ce_flag <= (ce_flag & ~ce_clr) | core_err_i;
      se_flag <= (se_flag & ~se_clr) | clk_err_i;
      if (wr_cen) ce_en <= reg_wdata[CE_LSB +: 4] & CE_KEEP;
      if (wr_sen) se_en <= reg_wdata[SE_LSB +: 2];
    end
  end

  generate
    if (LEGACY) begin : g_no_mask
      assign op_mask = 4'b0;
    end else begin : g_mask
      always_ff @(posedge clk) begin
        if (!rst_n)                              op_mask <= '0;
        else if (reg_wr && (reg_addr == A_MASK)) op_mask <= reg_wdata[EV_LSB +: 4];
      end
    end
  endgenerate

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_OP: begin
        reg_rdata[EV_LSB +: 4]   = op_ev;
        reg_rdata[LIVE_LSB +: 4] = fifo_live_i;
      end
      A_MASK: reg_rdata[EV_LSB +: 4] = op_mask;
      A_CEF:  reg_rdata[CE_LSB +: 4] = ce_flag;
      A_CEN:  reg_rdata[CE_LSB +: 4] = ce_en;
      A_SEF:  reg_rdata[SE_LSB +: 2] = se_flag;
      A_SEN:  reg_rdata[SE_LSB +: 2] = se_en;
      default: reg_rdata = '0;
    endcase
  end

  assign irq_o = |(ce_flag & ce_en) | |(se_flag & se_en) | |(op_ev & ~op_mask);

  assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_event_i != 4'b0) |=> ((op_ev & $past(op_event_i)) == $past(op_event_i)));

  assert_op_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_op |=> ((op_ev & $past(op_ev)) == $past(op_ev)));

  assert_core_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cef |=> ((ce_flag & $past(ce_flag)) == $past(ce_flag)));

  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(op_event_i) != 4'b0 || $past(core_err_i) != 4'b0 ||
                      $past(clk_err_i) != 2'b0 || $past(reg_wr)));

endmodule

// File: tb/test_status_irq_regs.sv
module test_status_irq_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_event_i = '0, fifo_live_i = '0, core_err_i = '0;
  logic [1:0]  clk_err_i = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata, rdata_l;
  logic        irq, irq_l;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  status_irq_regs #(.REG_W(32), .ADDR_W(3), .LEGACY(1'b0)) i_status_irq_regs (
    .clk(clk), .rst_n(rst_n), .op_event_i(op_event_i), .fifo_live_i(fifo_live_i),
    .core_err_i(core_err_i), .clk_err_i(clk_err_i), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata), .irq_o(irq));

  status_irq_regs #(.REG_W(32), .ADDR_W(3), .LEGACY(1'b1)) i_status_irq_regs_legacy (
    .clk(clk), .rst_n(rst_n), .op_event_i(op_event_i), .fifo_live_i(fifo_live_i),
    .core_err_i(core_err_i), .clk_err_i(clk_err_i), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_l), .irq_o(irq_l));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v, output logic [31:0] vl);
    reg_addr = a;
    #1;
    v = rdata;
    vl = rdata_l;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse(input logic [3:0] op, input logic [3:0] ce, input logic [1:0] se);
    op_event_i = op; core_err_i = ce; clk_err_i = se;
    @(negedge clk);
    op_event_i = '0; core_err_i = '0; clk_err_i = '0;
  endtask

  task automatic t_reset;
    logic [31:0] v, vl;
    rd(3'd0, v, vl); chk("R1 op", v, 32'h0);
    rd(3'd2, v, vl); chk("R1 core flags", v, 32'h0);
    rd(3'd4, v, vl); chk("R1 clk flags", v, 32'h0);
    rd(3'd1, v, vl); chk("R1 mask", v, 32'h0);
    rd(3'd3, v, vl); chk("R1 core enable", v, 32'h3C); chk("R1 legacy core enable", vl, 32'h38);
    rd(3'd5, v, vl); chk("R1 clk enable", v, 32'h3);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_op_fields;
    logic [31:0] v, vl;
    fifo_live_i = 4'b1010;
    rd(3'd0, v, vl); chk("R2 live bits", v, 32'hA0);
    pulse(4'b1010, 4'b0, 2'b0);
    rd(3'd0, v, vl); chk("R3 events 11 and 9 latched", v, 32'hAA0);
    chk("R8 irq on event", {31'b0, irq}, 32'h1);
    @(negedge clk);
    rd(3'd0, v, vl); chk("R3 events held", v, 32'hAA0);
    wr(3'd0, 32'h2F0);
    rd(3'd0, v, vl); chk("R4 selective clear, R2 live kept", v, 32'h8A0);
    chk("R8 irq still high", {31'b0, irq}, 32'h1);
    wr(3'd0, 32'h800);
    fifo_live_i = 4'b0101;
    rd(3'd0, v, vl); chk("R2 live follows input", v, 32'h50);
    chk("R8 irq low after clear", {31'b0, irq}, 32'h0);
    fifo_live_i = 4'b0;
  endtask

  task automatic t_errors;
    logic [31:0] v, vl;
    pulse(4'b0, 4'b1001, 2'b10);
    rd(3'd2, v, vl); chk("R5 core flags 5 and 2", v, 32'h24);
    rd(3'd4, v, vl); chk("R6 clk flag 1", v, 32'h2);
    wr(3'd2, 32'h20);
    rd(3'd2, v, vl); chk("R5 partial clear", v, 32'h04);
    wr(3'd4, 32'h1);
    rd(3'd4, v, vl); chk("R6 clear of 0 bit leaves flag", v, 32'h2);
    wr(3'd4, 32'h2);
    rd(3'd4, v, vl); chk("R6 cleared", v, 32'h0);
    wr(3'd2, 32'h04);
    rd(3'd2, v, vl); chk("R5 cleared", v, 32'h0);
    chk("R8 irq low", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_collision;
    logic [31:0] v, vl;
    pulse(4'b0001, 4'b0, 2'b0);
    op_event_i = 4'b0001; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h100;
    @(negedge clk);
    op_event_i = '0; reg_wr = 1'b0; reg_wdata = '0;
    rd(3'd0, v, vl); chk("R7 event beats clear", v, 32'h100);
    wr(3'd0, 32'h100);
    rd(3'd0, v, vl); chk("R7 later clear works", v, 32'h0);
  endtask

  task automatic t_enable_mask;
    logic [31:0] v, vl;
    wr(3'd3, 32'h0);
    pulse(4'b0, 4'b1000, 2'b0);
    rd(3'd2, v, vl); chk("R9 disabled error recorded", v, 32'h20);
    chk("R9 disabled error no irq", {31'b0, irq}, 32'h0);
    wr(3'd3, 32'h3C);
    chk("R9 enabling raises irq", {31'b0, irq}, 32'h1);
    wr(3'd2, 32'h20);
    chk("R8 irq drops on clear", {31'b0, irq}, 32'h0);
    wr(3'd1, 32'h100);
    rd(3'd1, v, vl); chk("R10 mask readback", v, 32'h100); chk("R11 legacy mask reads 0", vl, 32'h0);
    pulse(4'b0001, 4'b0, 2'b0);
    chk("R10 masked event no irq", {31'b0, irq}, 32'h0);
    chk("R11 legacy event unmasked", {31'b0, irq_l}, 32'h1);
    wr(3'd0, 32'h100);
    wr(3'd1, 32'h0);
    chk("R10 irq low after clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_legacy;
    logic [31:0] v, vl;
    pulse(4'b0, 4'b0001, 2'b0);
    rd(3'd2, v, vl); chk("R11 legacy input-overrun recorded", vl, 32'h04);
    chk("R11 main irq from input-overrun", {31'b0, irq}, 32'h1);
    chk("R11 legacy no irq from input-overrun", {31'b0, irq_l}, 32'h0);
    wr(3'd3, 32'h3C);
    rd(3'd3, v, vl); chk("R11 legacy enable bit 2 stuck", vl, 32'h38);
    chk("R11 legacy still no irq", {31'b0, irq_l}, 32'h0);
    wr(3'd2, 32'h04);
    chk("R8 main irq low", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_op_fields;
    t_errors;
    t_collision;
    t_enable_mask;
    t_legacy;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule